// File: doc/BRIEF.md
# Label-Gated Receive Word Latch with Host Output Mux

This block sits between a serial word receiver and a host. Each time the receiver finishes a word that passed its checks, it pulses `word_good` and presents the 32-bit word. The block then raises `tag_valid` and opens a recognition window of `WIN_CYC` clock cycles. The label is accepted in one of two ways. In external mode the decision comes from the `ext_match` pin. In internal mode the low byte of the word (the label) is compared with the `label_cfg` input. If the label is accepted inside the window and the host holds no unread word, the word is copied into the host latch and `data_ready` rises.

The host reads the latch through a bus modelled as an enable (`bus_oe`) plus data (`bus_data`). The bus is driven only while `oe_n` is low and `data_ready` is high. With `wide_sel` high, word bits 31..8 appear together and the label byte is dropped. With `wide_sel` low, the word is shown 16 bits at a time. The low half comes first, and a rising edge on `oe_n` moves to the high half, which `half_hi` reports. An active-low pulse on `ack_n` tells the block that the host has finished reading. It clears `data_ready` and `tag_valid`.

The recognition controller has three states. `RS_IDLE` waits for a word. `RS_WINDOW` counts the window. `RS_LOAD` is the single cycle in which the latch is written. Its transitions are:
- T_START: `RS_IDLE` to `RS_WINDOW` on `word_good`.
- T_RESTART: `RS_WINDOW` or `RS_LOAD` to `RS_WINDOW` on a new `word_good`.
- T_HIT: `RS_WINDOW` to `RS_LOAD` when the label is accepted and no word is pending.
- T_DROP: `RS_WINDOW` to `RS_IDLE` when the label is accepted while `data_ready` is high.
- T_EXPIRE: `RS_WINDOW` to `RS_IDLE` when the last window cycle passes without acceptance.
- T_DONE: `RS_LOAD` to `RS_IDLE`.

Top module: `arinc_label_latch`

## Requirements
- R1: After reset, `data_ready`, `tag_valid`, `half_hi` and `bus_oe` are all low, and `bus_data` is zero.
- R2: `tag_valid` is high in the cycle after a clock edge that samples `word_good` high. If an acknowledge arrives at that same edge, the new word still sets `tag_valid`.
- R3: With `ext_sel`=1, a word is accepted only if `ext_match` is sampled high at one of the `WIN_CYC` edges that follow the `word_good` edge. Its label byte plays no part in the decision.
- R4: With `ext_sel`=0, a word is accepted only if its bits 7..0 equal `label_cfg`. The `ext_match` input is ignored.
- R5: `data_ready` rises exactly one cycle after the edge at which the label is accepted. A word that is not accepted leaves `data_ready` and the latched word unchanged.
- R6: While `data_ready` is high, the latched word is never replaced, even when a newer word is accepted.
- R7: `bus_oe` is high only while `oe_n` is low and `data_ready` is high. When `bus_oe` is low, `bus_data` is zero.
- R8: With `wide_sel`=1, `bus_data` carries word bits 31..8 as bits 23..0.
- R9: With `wide_sel`=0, the low half is presented first after a load: `bus_data` = {8'h00, word[15:0]} with `half_hi`=0. A rising edge of `oe_n` while `data_ready` is high sets `half_hi`=1, and `bus_data` then becomes {8'h00, word[31:16]}.
- R10: When `ack_n` is sampled low, `data_ready`, `tag_valid` and `half_hi` clear. The one exception is `wide_sel`=0 with `data_ready` high and `half_hi` still 0: in that case the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_good | input | 1 | One-cycle pulse: a checked word is present |
| word_in | input | 32 | Received word; bits 7..0 are the label |
| ext_sel | input | 1 | 1 = external recognition, 0 = internal compare |
| ext_match | input | 1 | External "label recognised" input |
| label_cfg | input | 8 | Label value used for internal compare |
| wide_sel | input | 1 | 1 = 24-bit bus, 0 = 16-bit halves |
| oe_n | input | 1 | Active-low host data enable |
| ack_n | input | 1 | Active-low data-access-complete pulse |
| tag_valid | output | 1 | Latest checked word awaits service |
| data_ready | output | 1 | Host latch holds an unread word |
| half_hi | output | 1 | In 16-bit mode: high half is on the bus |
| bus_oe | output | 1 | Bus is being driven |
| bus_data | output | 24 | Bus data (zero when not driven) |

## Verification
In external mode, the delay from `word_good` to `ext_match` is swept from 1 cycle to two cycles past the window. This shows where the last accepted edge lies, and the `data_ready` rise is checked at its exact cycle. In internal mode, all 256 label values are tried while `ext_match` is held high. This separates the compare from the external pin and confirms that exactly one label loads. Separate patterns cover the following: a second accepted word arriving while data is pending, which must leave the old word on the bus; an acknowledge given before the high half has been shown, which must be ignored; and reads in both bus widths, with expected slices computed from the word.

// File: rtl/arinc_latch_pkg.sv
package arinc_latch_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_WINDOW = 2'd1,
        RS_LOAD   = 2'd2
    } rec_state_e;
endpackage

// File: rtl/lbl_recog.sv
module lbl_recog #(
    parameter int LBL_W = 8
) (
    input  logic             ext_sel,
    input  logic             ext_match,
    input  logic [LBL_W-1:0] tag,
    input  logic [LBL_W-1:0] label_cfg,
    output logic             hit
);
    logic int_hit;

    assign int_hit = (tag == label_cfg);

    always_comb begin
        if (ext_sel) hit = ext_match;
        else         hit = int_hit;
    end
endmodule

// File: rtl/rec_window_fsm.sv
module rec_window_fsm
    import arinc_latch_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hit,
    input  logic pending,
    output logic load_pulse,
    output logic win_open
);
    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    rec_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: begin
                if (start) begin              // T_START
                    state_d = RS_WINDOW;
                    cnt_d   = '0;
                end
            end
            RS_WINDOW: begin
                if (start) begin              // T_RESTART
                    state_d = RS_WINDOW;
                    cnt_d   = '0;
                end else if (hit && !pending) begin
                    state_d = RS_LOAD;        // T_HIT
                end else if (hit) begin
                    state_d = RS_IDLE;        // T_DROP
                end else if (cnt_q == LAST) begin
                    state_d = RS_IDLE;        // T_EXPIRE
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RS_LOAD: begin
                if (start) begin              // T_RESTART
                    state_d = RS_WINDOW;
                    cnt_d   = '0;
                end else begin
                    state_d = RS_IDLE;        // T_DONE
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_pulse = (state_q == RS_LOAD);
        win_open   = (state_q == RS_WINDOW);
    end
endmodule

// File: rtl/host_out_mux.sv
module host_out_mux #(
    parameter int DATA_W = 32,
    parameter int LBL_W  = 8,
    parameter int HALF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       word,
    input  logic                    data_ready,
    input  logic                    load,
    input  logic                    ack_ok,
    input  logic                    oe_n,
    input  logic                    wide_sel,
    output logic                    half_hi,
    output logic                    bus_oe,
    output logic [DATA_W-LBL_W-1:0] bus_data
);
    localparam int WIDE_W = DATA_W - LBL_W;

    logic             oe_prev_q;
    logic             half_q;
    logic             oe_rise;
    logic [HALF_W-1:0] half_word;
    logic [WIDE_W-1:0] narrow_bus;

    assign oe_rise = oe_n && !oe_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_prev_q <= 1'b1;
            half_q    <= 1'b0;
        end else begin
            oe_prev_q <= oe_n;
            if (load || ack_ok)
                half_q <= 1'b0;
            else if (oe_rise && data_ready && !wide_sel)
                half_q <= 1'b1;
        end
    end

    assign half_word = half_q ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];

    generate
        if (WIDE_W > HALF_W) begin : g_pad
            assign narrow_bus = {{(WIDE_W-HALF_W){1'b0}}, half_word};
        end else begin : g_nopad
            assign narrow_bus = half_word[WIDE_W-1:0];
        end
    endgenerate

    assign half_hi = half_q;
    assign bus_oe  = !oe_n && data_ready;

    always_comb begin
        if (!bus_oe)       bus_data = '0;
        else if (wide_sel) bus_data = word[DATA_W-1:LBL_W];
        else               bus_data = narrow_bus;
    end
endmodule

// File: rtl/arinc_label_latch.sv
module arinc_label_latch #(
    parameter int DATA_W  = 32,
    parameter int LBL_W   = 8,
    parameter int WIN_CYC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_good,
    input  logic [DATA_W-1:0]       word_in,
    input  logic                    ext_sel,
    input  logic                    ext_match,
    input  logic [LBL_W-1:0]        label_cfg,
    input  logic                    wide_sel,
    input  logic                    oe_n,
    input  logic                    ack_n,
    output logic                    tag_valid,
    output logic                    data_ready,
    output logic                    half_hi,
    output logic                    bus_oe,
    output logic [DATA_W-LBL_W-1:0] bus_data
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] word_q;
    logic              ready_q;
    logic              tagv_q;
    logic              hit;
    logic              load_pulse;
    logic              win_open;
    logic              ack_ok;

    lbl_recog #(.LBL_W(LBL_W)) u_recog (
        .ext_sel   (ext_sel),
        .ext_match (ext_match),
        .tag       (stage_q[LBL_W-1:0]),
        .label_cfg (label_cfg),
        .hit       (hit)
    );

    rec_window_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (word_good),
        .hit        (hit),
        .pending    (ready_q),
        .load_pulse (load_pulse),
        .win_open   (win_open)
    );

    // acknowledge counts only once both halves were offered in narrow mode
    assign ack_ok = !ack_n && !(!wide_sel && ready_q && !half_hi);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            word_q  <= '0;
            ready_q <= 1'b0;
            tagv_q  <= 1'b0;
        end else begin
            if (word_good) stage_q <= word_in;
            if (load_pulse) begin
                word_q  <= stage_q;
                ready_q <= 1'b1;
            end else if (ack_ok) begin
                ready_q <= 1'b0;
            end
            if (word_good)   tagv_q <= 1'b1;
            else if (ack_ok) tagv_q <= 1'b0;
        end
    end

    host_out_mux #(.DATA_W(DATA_W), .LBL_W(LBL_W), .HALF_W(HALF_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word_q),
        .data_ready (ready_q),
        .load       (load_pulse),
        .ack_ok     (ack_ok),
        .oe_n       (oe_n),
        .wide_sel   (wide_sel),
        .half_hi    (half_hi),
        .bus_oe     (bus_oe),
        .bus_data   (bus_data)
    );

    assign tag_valid  = tagv_q;
    assign data_ready = ready_q;
endmodule

// File: rtl/arinc_label_latch_chk.sv
module arinc_label_latch_chk #(
    parameter int DATA_W = 32,
    parameter int LBL_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    word_good,
    input logic                    ack_n,
    input logic                    oe_n,
    input logic                    tag_valid,
    input logic                    data_ready,
    input logic                    half_hi,
    input logic                    bus_oe,
    input logic [DATA_W-LBL_W-1:0] bus_data,
    input logic [DATA_W-1:0]       word_q,
    input logic                    load_pulse
);
    AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_good) |-> tag_valid); // R2

    AST_READY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(load_pulse)); // R5

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && $past(data_ready)) |-> $stable(word_q)); // R6

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !data_ready) |-> (!bus_oe && bus_data == '0)); // R7

    AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> !half_hi); // R9

    AST_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> !$past(ack_n)); // R10
endmodule

bind arinc_label_latch arinc_label_latch_chk #(.DATA_W(DATA_W), .LBL_W(LBL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_good  (word_good),
    .ack_n      (ack_n),
    .oe_n       (oe_n),
    .tag_valid  (tag_valid),
    .data_ready (data_ready),
    .half_hi    (half_hi),
    .bus_oe     (bus_oe),
    .bus_data   (bus_data),
    .word_q     (word_q),
    .load_pulse (load_pulse)
);

// File: tb/sim_arinc_label_latch.sv
module sim_arinc_label_latch;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_good;
    logic [31:0] word_in;
    logic        ext_sel;
    logic        ext_match;
    logic [7:0]  label_cfg;
    logic        wide_sel;
    logic        oe_n;
    logic        ack_n;
    logic        tag_valid;
    logic        data_ready;
    logic        half_hi;
    logic        bus_oe;
    logic [23:0] bus_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arinc_label_latch #(.DATA_W(32), .LBL_W(8), .WIN_CYC(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .word_good(word_good), .word_in(word_in),
        .ext_sel(ext_sel), .ext_match(ext_match), .label_cfg(label_cfg),
        .wide_sel(wide_sel), .oe_n(oe_n), .ack_n(ack_n),
        .tag_valid(tag_valid), .data_ready(data_ready), .half_hi(half_hi),
        .bus_oe(bus_oe), .bus_data(bus_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input int n, input logic [7:0] lbl);
        logic [23:0] hi;
        hi = 24'(n * 24'h3B1F07) ^ 24'hC0FFEE;
        return {hi, lbl};
    endfunction

    task automatic send(input logic [31:0] w);
        word_in = w; word_good = 1'b1;
        @(negedge clk);
        word_good = 1'b0;
        chk("R2 tag_valid set", tag_valid, 1);
    endtask

    task automatic ack();
        ack_n = 1'b0;
        @(negedge clk);
        ack_n = 1'b1;
    endtask

    task automatic read16(input logic [31:0] w);
        oe_n = 1'b0; #1;
        chk("R9 low half first", {8'h0, bus_oe, half_hi, bus_data}, {8'h0, 2'b10, 8'h00, w[15:0]});
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
        chk("R9 half_hi after oe_n rise", half_hi, 1);
        chk("R7 bus idle with oe_n high", {bus_oe, bus_data}, 0);
        oe_n = 1'b0; #1;
        chk("R9 high half", bus_data, {8'h00, w[31:16]});
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read24(input logic [31:0] w);
        oe_n = 1'b0; #1;
        chk("R8 wide bus", {bus_oe, bus_data}, {1'b1, w[31:8]});
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] w, w2;
        rst_n = 1'b0; word_good = 0; word_in = 0; ext_sel = 1; ext_match = 0;
        label_cfg = 8'hA5; wide_sel = 0; oe_n = 1; ack_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset flags", {data_ready, tag_valid, half_hi, bus_oe}, 0);
        chk("R1 reset bus", bus_data, 0);

        // external recognition delay sweep, 16-bit reads
        for (int d = 1; d <= WIN + 2; d++) begin
            ext_sel = 1'b1; wide_sel = 1'b0;
            w = mkword(d, 8'hA5 ^ 8'(d));
            send(w);
            repeat (d - 1) @(negedge clk);
            ext_match = 1'b1;
            @(negedge clk);
            chk("R5 not yet ready", data_ready, 0);
            @(negedge clk);
            chk("R3 window edge / R5 ready timing", data_ready, (d <= WIN) ? 1 : 0);
            repeat (2) @(negedge clk);
            ext_match = 1'b0;
            if (d <= WIN) begin
                ack();
                chk("R10 early ack ignored", {data_ready, tag_valid}, 2'b11);
                read16(w);
                ack();
                chk("R10 ack clears", {data_ready, tag_valid, half_hi}, 0);
            end else begin
                oe_n = 1'b0; #1;
                chk("R5 miss keeps bus off", {bus_oe, bus_data}, 0);
                @(negedge clk); oe_n = 1'b1;
                ack();
                chk("R10 ack clears tag_valid", tag_valid, 0);
            end
        end

        // external mode: matching label but no ext_match
        ext_sel = 1'b1;
        send(mkword(50, 8'hA5));
        repeat (WIN + 3) @(negedge clk);
        chk("R3 label ignored in external mode", data_ready, 0);
        ack();

        // internal compare: all labels, ext_match held high
        ext_sel = 1'b0; wide_sel = 1'b1; ext_match = 1'b1;
        for (int t = 0; t < 256; t++) begin
            w = mkword(t + 100, 8'(t));
            send(w);
            repeat (WIN + 3) @(negedge clk);
            chk("R4 internal compare", data_ready, (t == 8'hA5) ? 1 : 0);
            if (t == 8'hA5) begin
                read24(w);
                ack();
                chk("R10 wide ack", {data_ready, tag_valid}, 0);
            end else begin
                ack();
            end
        end
        ext_match = 1'b0;

        // no overwrite while pending
        ext_sel = 1'b1; wide_sel = 1'b1;
        w = mkword(7, 8'h11);
        send(w); ext_match = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 loaded first word", data_ready, 1);
        w2 = mkword(9, 8'h22);
        send(w2);
        repeat (WIN + 2) @(negedge clk);
        ext_match = 1'b0;
        chk("R6 still pending", data_ready, 1);
        read24(w);
        wide_sel = 1'b0;
        read16(w);
        ack();
        chk("R10 final ack", {data_ready, half_hi}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule